// File: doc/BRIEF.md
# Cascaded H-Bridge Pulse Rotator

This block spreads the PWM pulses of one inverter phase over the series-connected H-bridges of that phase. Upstream logic compares the reference against the carrier and asks for one output pulse at a time, with a sign. The rotator gives each new pulse to the next physical bridge in a fixed circular order. Every bridge therefore fires once per pass through the chain. The sum of the bridge outputs still carries the full pulse train. With N bridges in the chain, each device switches at 1/N of the phase pulse rate.

A half-cycle strobe loads the pulse count requested for the next half of the fundamental. If that count is a whole multiple of the bridge count, every bridge would see the same widths in every half-cycle and its source would drain at its own rate. The block detects such a count, moves it by one pulse, and raises a flag.

Top module: `chb_rotor`

## Requirements
- R1: After reset, every bridge command is 0 and the summed level is 0. The first pulse goes to bridge 0. The latched count is 1 and the adjust flag is 0.
- R2: When `pulseActive` is first sampled high at a clock edge, the selected bridge takes the pulse at that same edge. A positive pulse (`pulseNeg`=0) drives the 2-bit two's-complement field `bridgeCmd[2i+1:2i]` to 01 (+1). A negative pulse drives it to 11 (-1).
- R3: Successive pulses go to bridges 0, 1, …, NUM_BRIDGES-1 and then wrap to 0. The pointer moves one step per pulse.
- R4: At most one bridge field is nonzero at any time. `phaseLevel` equals the signed sum of all bridge fields.
- R5: At the edge where `pulseActive` is first sampled low, every bridge field returns to 0 and `phaseLevel` becomes 0.
- R6: The sign of a pulse is captured when the pulse starts. Changes on `pulseNeg` while the pulse is active have no effect on the outputs.
- R7: `halfCycle` does not reset the rotation pointer. The pulse after a strobe goes to the bridge that follows the one used by the pulse before it.
- R8: When `halfCycle` is high, `pulseCountReq` is latched into `pulseCountOut` at that edge. A count that is not a multiple of NUM_BRIDGES passes unchanged and clears `countAdjusted`.
- R9: A requested count that is a multiple of NUM_BRIDGES, zero included, is latched as count+1 and sets `countAdjusted`. If the request is the all-ones maximum, it is latched as count-1 instead.
- R10: Between strobes, `pulseCountOut` and `countAdjusted` hold their values whatever `pulseCountReq` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pulseActive | input | 1 | High for the duration of a requested phase pulse |
| pulseNeg | input | 1 | Pulse sign: 0 positive, 1 negative |
| halfCycle | input | 1 | Fundamental half-cycle strobe, loads the pulse count |
| pulseCountReq | input | CNT_W | Requested pulses for the next half-cycle |
| bridgeCmd | output | 2*NUM_BRIDGES | Per-bridge command, two's complement +1/0/-1, bridge i at bits 2i+1:2i |
| phaseLevel | output | LVL_W | Signed sum of all bridge commands |
| pulseCountOut | output | CNT_W | Latched, rule-corrected pulse count |
| countAdjusted | output | 1 | Latched count was moved off a multiple of NUM_BRIDGES |

## Verification
The bench uses the defaults: five bridges, as in an eleven-level phase, and a 4-bit count. Seven pulses are enough to pass the wrap from bridge 4 back to bridge 0. The 4-bit maximum of 15 is itself a multiple of five, so the downward adjustment at the top of the range can be reached. Zero, 5 and 10 exercise the upward adjustment. A half-cycle strobe comes before each pulse, which shows that the rotation continues across strobes.

// File: rtl/chb_rotor_pkg.sv
package chb_rotor_pkg;
  localparam int SEL_W = 8;

  typedef struct packed {
    logic             startPulse;
    logic             endPulse;
    logic             negative;
    logic [SEL_W-1:0] sel;
  } rotStrobe_t;
endpackage

// File: rtl/chb_rotor_ctrl.sv
module chb_rotor_ctrl
  import chb_rotor_pkg::*;
#(
  parameter int NUM_BRIDGES = 5,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pulseActive,
  input  logic             pulseNeg,
  input  logic             halfCycle,
  input  logic [CNT_W-1:0] pulseCountReq,
  output rotStrobe_t       strobe,
  output logic [CNT_W-1:0] pulseCountOut,
  output logic             countAdjusted
);
  localparam int PW = (NUM_BRIDGES > 1) ? $clog2(NUM_BRIDGES) : 1;
  localparam logic [PW-1:0] LAST = PW'(NUM_BRIDGES - 1);

  logic          prevActive;
  logic [PW-1:0] ptr;
  logic          reqIsMultiple;
  logic [CNT_W-1:0] fixedCount;

  assign strobe.startPulse = pulseActive & ~prevActive;
  assign strobe.endPulse   = ~pulseActive & prevActive;
  assign strobe.negative   = pulseNeg;
  assign strobe.sel        = SEL_W'(ptr);

  // Rotation pointer: one step per new pulse, never cleared by the strobe.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevActive <= 1'b0;
      ptr        <= '0;
    end else begin
      prevActive <= pulseActive;
      if (strobe.startPulse) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  // Pulse-count rule: keep the count off multiples of the bridge count.
  always_comb begin
    reqIsMultiple = ((int'(pulseCountReq) % NUM_BRIDGES) == 0);
    if (!reqIsMultiple)             fixedCount = pulseCountReq;
    else if (pulseCountReq == '1)   fixedCount = pulseCountReq - 1'b1;
    else                            fixedCount = pulseCountReq + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseCountOut <= CNT_W'(1);
      countAdjusted <= 1'b0;
    end else if (halfCycle) begin
      pulseCountOut <= fixedCount;
      countAdjusted <= reqIsMultiple;
    end
  end

  assert_ptr_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    int'(ptr) < NUM_BRIDGES);
  assert_ptr_moves_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startPulse |=> ptr != $past(ptr));
  assert_ptr_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.startPulse |=> $stable(ptr));
  assert_count_legal_R9: assert property (@(posedge clk) disable iff (!rstN)
    (int'(pulseCountOut) % NUM_BRIDGES) != 0);
  assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !halfCycle |=> $stable(pulseCountOut) && $stable(countAdjusted));
endmodule

// File: rtl/chb_rotor_dp.sv
module chb_rotor_dp
  import chb_rotor_pkg::*;
#(
  parameter int NUM_BRIDGES = 5,
  parameter int LVL_W       = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  rotStrobe_t               strobe,
  output logic [2*NUM_BRIDGES-1:0] bridgeCmd,
  output logic signed [LVL_W-1:0]  phaseLevel
);
  logic signed [1:0]      cmd [NUM_BRIDGES];
  logic [NUM_BRIDGES-1:0] nonZero;

  for (genvar i = 0; i < NUM_BRIDGES; i++) begin : g_bridge
    always_ff @(posedge clk) begin
      if (!rstN)
        cmd[i] <= 2'sd0;
      else if (strobe.startPulse && (int'(strobe.sel) == i))
        cmd[i] <= strobe.negative ? -2'sd1 : 2'sd1;
      else if (strobe.endPulse)
        cmd[i] <= 2'sd0;
    end
    assign bridgeCmd[2*i +: 2] = cmd[i];
    assign nonZero[i]          = (cmd[i] != 2'sd0);
  end

  always_comb begin
    phaseLevel = '0;
    for (int i = 0; i < NUM_BRIDGES; i++) phaseLevel = phaseLevel + LVL_W'(cmd[i]);
  end

  assert_one_bridge_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(nonZero));
  assert_idle_after_end_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.endPulse |=> phaseLevel == '0);
  assert_sign_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.startPulse && !strobe.endPulse) |=> $stable(bridgeCmd));
endmodule

// File: rtl/chb_rotor.sv
module chb_rotor
  import chb_rotor_pkg::*;
#(
  parameter int NUM_BRIDGES = 5,
  parameter int CNT_W       = 4,
  localparam int LVL_W      = $clog2(NUM_BRIDGES + 1) + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     pulseActive,
  input  logic                     pulseNeg,
  input  logic                     halfCycle,
  input  logic [CNT_W-1:0]         pulseCountReq,
  output logic [2*NUM_BRIDGES-1:0] bridgeCmd,
  output logic signed [LVL_W-1:0]  phaseLevel,
  output logic [CNT_W-1:0]         pulseCountOut,
  output logic                     countAdjusted
);
  rotStrobe_t strobe;

  chb_rotor_ctrl #(.NUM_BRIDGES(NUM_BRIDGES), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .pulseActive(pulseActive), .pulseNeg(pulseNeg),
    .halfCycle(halfCycle), .pulseCountReq(pulseCountReq), .strobe(strobe),
    .pulseCountOut(pulseCountOut), .countAdjusted(countAdjusted)
  );

  chb_rotor_dp #(.NUM_BRIDGES(NUM_BRIDGES), .LVL_W(LVL_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .bridgeCmd(bridgeCmd), .phaseLevel(phaseLevel)
  );
endmodule

// File: tb/chb_rotor_test.sv
module chb_rotor_test;
  localparam int NB = 5;
  localparam int CW = 4;
  localparam int LW = $clog2(NB + 1) + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pulseActive = 1'b0;
  logic pulseNeg = 1'b0;
  logic halfCycle = 1'b0;
  logic [CW-1:0] pulseCountReq = '0;
  logic [2*NB-1:0] bridgeCmd;
  logic signed [LW-1:0] phaseLevel;
  logic [CW-1:0] pulseCountOut;
  logic countAdjusted;

  int checks = 0;
  int errors = 0;
  int expIdx = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  chb_rotor uut (
    .clk(clk), .rstN(rstN), .pulseActive(pulseActive), .pulseNeg(pulseNeg),
    .halfCycle(halfCycle), .pulseCountReq(pulseCountReq), .bridgeCmd(bridgeCmd),
    .phaseLevel(phaseLevel), .pulseCountOut(pulseCountOut), .countAdjusted(countAdjusted)
  );

  // {request, negative, expected count, expected flag}
  localparam logic [9:0] VEC [7] = '{
    {4'd3,  1'b0, 4'd3,  1'b0},
    {4'd5,  1'b1, 4'd6,  1'b1},
    {4'd7,  1'b0, 4'd7,  1'b0},
    {4'd0,  1'b1, 4'd1,  1'b1},
    {4'd15, 1'b0, 4'd14, 1'b1},
    {4'd10, 1'b1, 4'd11, 1'b1},
    {4'd9,  1'b0, 4'd9,  1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int field(input int i);
    return int'($signed(bridgeCmd[2*i +: 2]));
  endfunction

  task automatic checkBridges(input string req, input int idx, input int val);
    for (int i = 0; i < NB; i++) check(req, field(i), (i == idx) ? val : 0);
    check(req, int'(phaseLevel), val);
  endtask

  task automatic doStrobe(input logic [CW-1:0] req);
    @(negedge clk);
    halfCycle = 1'b1;
    pulseCountReq = req;
    @(negedge clk);
    halfCycle = 1'b0;
  endtask

  task automatic doPulse(input string req, input logic neg, input int len);
    int val;
    val = neg ? -1 : 1;
    @(negedge clk);
    pulseActive = 1'b1;
    pulseNeg = neg;
    @(negedge clk);
    checkBridges(req, expIdx, val);
    for (int k = 1; k < len; k++) @(negedge clk);
    pulseActive = 1'b0;
    @(negedge clk);
    checkBridges("R5", -1, 0);
    expIdx = (expIdx + 1) % NB;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checkBridges("R1", -1, 0);
    check("R1", int'(pulseCountOut), 1);
    check("R1", int'(countAdjusted), 0);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk: strobe loads count (R8/R9), pulse rotates (R2/R3/R4/R7)
    for (int v = 0; v < 7; v++) begin
      doStrobe(VEC[v][9:6]);
      check("R8_R9 count", int'(pulseCountOut), int'(VEC[v][4:1]));
      check("R8_R9 flag", int'(countAdjusted), int'(VEC[v][0]));
      doPulse("R2_R3_R4_R7", VEC[v][5], 2 + v);
    end

    // R10: request changes without a strobe have no effect
    @(negedge clk);
    pulseCountReq = 4'd5;
    repeat (3) @(negedge clk);
    check("R10 count", int'(pulseCountOut), 9);
    check("R10 flag", int'(countAdjusted), 0);

    // R6: sign flip during an active pulse is ignored
    @(negedge clk);
    pulseActive = 1'b1;
    pulseNeg = 1'b0;
    @(negedge clk);
    pulseNeg = 1'b1;
    repeat (2) @(negedge clk);
    checkBridges("R6", expIdx, 1);
    pulseActive = 1'b0;
    @(negedge clk);
    checkBridges("R6", -1, 0);
    expIdx = (expIdx + 1) % NB;

    // R7: strobe with unchanged count, next pulse continues the rotation
    doStrobe(4'd4);
    check("R7 count", int'(pulseCountOut), 4);
    doPulse("R7", 1'b1, 1);

    // R1: mid-pulse reset clears outputs and restarts at bridge 0
    @(negedge clk);
    pulseActive = 1'b1;
    pulseNeg = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    pulseActive = 1'b0;
    @(negedge clk);
    checkBridges("R1", -1, 0);
    check("R1", int'(pulseCountOut), 1);
    rstN = 1'b1;
    expIdx = 0;
    doPulse("R1_R3", 1'b0, 1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule